// File: doc/BRIEF.md
# Multiplexed Address/Data Asynchronous Read Controller

This block runs single asynchronous read cycles toward an external parallel memory. The memory shares one 16-bit bus between the low address bits and the data bits. A request is taken only while the controller is idle. The controller then counts functional-clock ticks from the start of the cycle. Each edge of chip select, address valid and output enable falls at its own programmed tick, and the direction of the shared bus follows from the output-enable timing.

At the start of the cycle the low word-address bits go out on the shared bus. The higher address bits go out on a separate address-only bus, and the byte enables are driven as well. When output enable asserts, the controller releases the shared bus and marks the direction as inbound. It samples the bus at a programmed access tick. When the programmed cycle length has elapsed, it returns the captured word with a one-cycle done pulse. The timing words, address and byte enables are latched when the request is accepted. A timing set that cannot work does not stop the cycle. The affected strobe simply stays inactive and an error flag is raised.

Top module: `mux_ad_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o, adv_n_o and oe_n_o are 1; busy_o, done_o, ad_oe_o, dir_o and err_o are 0; be_n_o is all ones and addr_hi_o is zero.
- R2: A request (req_i high at a rising edge) is accepted only while busy_o is low. Requests and any changes to the address, byte-enable or timing inputs while busy have no effect on the cycle in progress.
- R3: Tick 0 is the first clock cycle after the accepting edge. busy_o is high from tick 0 through tick cyc_i inclusive. done_o is high for exactly the one cycle after tick cyc_i, and busy_o is low in that cycle.
- R4: cs_n_o is 0 exactly in the ticks t with cs_on_i <= t < cs_off_i, and 1 otherwise.
- R5: adv_n_o is 0 exactly in the ticks t with adv_on_i <= t < adv_off_i, and 1 otherwise.
- R6: oe_n_o is 0 exactly in the ticks t with oe_on_i <= t < oe_off_i, and 1 otherwise.
- R7: During the cycle, addr_hi_o equals request address bits [AW-1:17], be_n_o equals the latched byte enables (active low), and ad_o carries address bits [16:1]. addr_hi_o keeps its value after the cycle; be_n_o is all ones when idle.
- R8: ad_oe_o and dir_o (1 = outbound, 0 = inbound) are 1 from tick 0 until the tick at which oe_n_o first goes to 0. From that tick to the end of the cycle they are 0. They are 0 when idle, and ad_oe_o is never 1 while oe_n_o is 0. If output enable never asserts, the bus is driven for the whole cycle.
- R9: The value of ad_i in tick acc_i is captured and presented on rdata_o during the done cycle.
- R10: A strobe whose on-time is not below its off-time, or whose off-time exceeds cyc_i, stays at 1 for the whole cycle and sets err_o. An acc_i above cyc_i also sets err_o, and in that case rdata_o reads 0. err_o is held from tick 0 until the next acceptance, and the cycle still completes as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, sampled at rising edges |
| addr_i | input | AW-1 (26) | Word address, bits [AW-1:1] |
| be_n_i | input | BEW (2) | Byte enables for the access, active low |
| cs_on_i | input | ONW (4) | Chip-select assertion tick |
| cs_off_i | input | TW (5) | Chip-select deassertion tick |
| adv_on_i | input | ONW (4) | Address-valid assertion tick |
| adv_off_i | input | TW (5) | Address-valid deassertion tick |
| oe_on_i | input | ONW (4) | Output-enable assertion tick |
| oe_off_i | input | TW (5) | Output-enable deassertion tick |
| acc_i | input | TW (5) | Data capture tick |
| cyc_i | input | TW (5) | Last tick of the cycle |
| ad_i | input | DW (16) | Shared bus, inbound value |
| ad_o | output | DW (16) | Shared bus, outbound value (address bits [16:1]) |
| ad_oe_o | output | 1 | Shared bus driver enable |
| dir_o | output | 1 | Bus direction, 1 = outbound, 0 = inbound |
| addr_hi_o | output | AW-DW-1 (10) | Upper address bus |
| be_n_o | output | BEW (2) | Byte enables to the device, active low |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address valid, active low |
| oe_n_o | output | 1 | Output enable, active low |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW (16) | Captured read word, valid with done_o |
| err_o | output | 1 | Latched timing-set error for the current or last cycle |

## Verification
Some properties are checked on every cycle. The shared-bus driver and output enable are never active together. The upper address and byte enables do not move while a cycle runs. The tick counter advances by one per cycle until the last tick, and done is a single-cycle pulse that follows the fall of busy. A strobe flagged as invalid never asserts, and captured data changes only at acceptance or at the access tick. Other behaviour only the bench scenarios can show:

- the exact tick at which each strobe edge falls under different timing sets;
- the one-tick placement of the capture at the edges of the output-enable window;
- gating of requests and input changes during a cycle, including back-to-back cycles;
- the error flag and zeroed data for unworkable timing sets, and the error flag clearing on the next good cycle.

// File: rtl/mad_pkg.sv
package mad_pkg;

    // number of timed strobes and their slots in the strobe arrays
    localparam int NSTRB = 3;
    localparam int S_CS  = 0;
    localparam int S_ADV = 1;
    localparam int S_OE  = 2;

    // a strobe window is usable when it opens before it closes and
    // closes no later than the last tick of the cycle
    function automatic logic win_ok(input int unsigned on_t,
                                    input int unsigned off_t,
                                    input int unsigned last_t);
        return (on_t < off_t) && (off_t <= last_t);
    endfunction

    // the capture tick must fall inside the cycle
    function automatic logic tick_in(input int unsigned t,
                                     input int unsigned last_t);
        return t <= last_t;
    endfunction

endpackage

// File: rtl/mad_seq.sv
module mad_seq #(
    parameter int TW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [TW-1:0] cyc_i,
    output logic          accept_o,
    output logic          busy_o,
    output logic [TW-1:0] tick_o,
    output logic          done_o
);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] tick;
        logic [TW-1:0] last;
        logic          done;
    } seq_st_t;

    localparam seq_st_t SEQ_RST = '{busy: 1'b0, tick: '0, last: '0, done: 1'b0};

    seq_st_t seq_d, seq_q;

    assign accept_o = req_i && !seq_q.busy;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (seq_q.busy) begin
            if (seq_q.tick == seq_q.last) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.tick = seq_q.tick + TW'(1);
            end
        end else if (accept_o) begin
            seq_d.busy = 1'b1;
            seq_d.tick = '0;
            seq_d.last = cyc_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= SEQ_RST;
        else         seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign tick_o = seq_q.tick;
    assign done_o = seq_q.done;

    // R3
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R2
    tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.busy && (seq_q.tick != seq_q.last))
        |=> (seq_q.busy && (seq_q.tick == $past(seq_q.tick) + TW'(1))));

    // R3
    end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

endmodule

// File: rtl/mad_strobe.sv
module mad_strobe #(
    parameter int TW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          accept_i,
    input  logic [TW-1:0] on_i,
    input  logic [TW-1:0] off_i,
    input  logic [TW-1:0] cyc_i,
    input  logic          busy_i,
    input  logic [TW-1:0] tick_i,
    output logic          active_o,
    output logic          bad_o
);

    typedef struct packed {
        logic [TW-1:0] on_t;
        logic [TW-1:0] off_t;
        logic          ok;
    } stb_st_t;

    localparam stb_st_t STB_RST = '{on_t: '0, off_t: '0, ok: 1'b1};

    stb_st_t stb_d, stb_q;

    always_comb begin
        stb_d = stb_q;
        if (accept_i) begin
            stb_d.on_t  = on_i;
            stb_d.off_t = off_i;
            stb_d.ok    = mad_pkg::win_ok(32'(on_i), 32'(off_i), 32'(cyc_i));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stb_q <= STB_RST;
        else         stb_q <= stb_d;
    end

    assign active_o = busy_i && stb_q.ok
                   && (tick_i >= stb_q.on_t) && (tick_i < stb_q.off_t);
    assign bad_o    = !stb_q.ok;

    // R10
    bad_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_o |-> !active_o);

    // R4
    active_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_o |-> busy_i);

endmodule

// File: rtl/mad_capture.sv
module mad_capture #(
    parameter int TW = 5,
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          accept_i,
    input  logic [TW-1:0] acc_i,
    input  logic [TW-1:0] cyc_i,
    input  logic          busy_i,
    input  logic [TW-1:0] tick_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] data_o,
    output logic          bad_o
);

    typedef struct packed {
        logic [TW-1:0] acc;
        logic          ok;
        logic [DW-1:0] data;
    } cap_st_t;

    localparam cap_st_t CAP_RST = '{acc: '0, ok: 1'b1, data: '0};

    cap_st_t cap_d, cap_q;
    logic    sample;

    assign sample = busy_i && cap_q.ok && (tick_i == cap_q.acc);

    always_comb begin
        cap_d = cap_q;
        if (accept_i) begin
            cap_d.acc  = acc_i;
            cap_d.ok   = mad_pkg::tick_in(32'(acc_i), 32'(cyc_i));
            cap_d.data = '0;
        end else if (sample) begin
            cap_d.data = ad_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= CAP_RST;
        else         cap_q <= cap_d;
    end

    assign data_o = cap_q.data;
    assign bad_o  = !cap_q.ok;

    // R9
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!accept_i && !(busy_i && (tick_i == cap_q.acc))) |=> $stable(data_o));

endmodule

// File: rtl/mux_ad_rd_ctrl.sv
module mux_ad_rd_ctrl #(
    parameter int AW  = 27,
    parameter int DW  = 16,
    parameter int BEW = 2,
    parameter int ONW = 4,
    parameter int TW  = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    input  logic [AW-1:1]       addr_i,
    input  logic [BEW-1:0]      be_n_i,
    input  logic [ONW-1:0]      cs_on_i,
    input  logic [TW-1:0]       cs_off_i,
    input  logic [ONW-1:0]      adv_on_i,
    input  logic [TW-1:0]       adv_off_i,
    input  logic [ONW-1:0]      oe_on_i,
    input  logic [TW-1:0]       oe_off_i,
    input  logic [TW-1:0]       acc_i,
    input  logic [TW-1:0]       cyc_i,
    input  logic [DW-1:0]       ad_i,
    output logic [DW-1:0]       ad_o,
    output logic                ad_oe_o,
    output logic                dir_o,
    output logic [AW-DW-2:0]    addr_hi_o,
    output logic [BEW-1:0]      be_n_o,
    output logic                cs_n_o,
    output logic                adv_n_o,
    output logic                oe_n_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [DW-1:0]       rdata_o,
    output logic                err_o
);

    import mad_pkg::*;

    localparam int HW = AW - DW - 1;

    typedef struct packed {
        logic [DW-1:0]  lo;
        logic [HW-1:0]  hi;
        logic [BEW-1:0] be_n;
        logic           rel;
    } hold_t;

    localparam hold_t HOLD_RST = '{lo: '0, hi: '0, be_n: '1, rel: 1'b0};

    logic                accept;
    logic                busy;
    logic                done;
    logic [TW-1:0]       tick;
    logic [TW-1:0]       on_a  [NSTRB];
    logic [TW-1:0]       off_a [NSTRB];
    logic [NSTRB-1:0]    act;
    logic [NSTRB-1:0]    bad;
    logic                acc_bad;
    logic [DW-1:0]       cap_data;
    hold_t               hold_d, hold_q;

    assign on_a[S_CS]   = TW'(cs_on_i);
    assign off_a[S_CS]  = cs_off_i;
    assign on_a[S_ADV]  = TW'(adv_on_i);
    assign off_a[S_ADV] = adv_off_i;
    assign on_a[S_OE]   = TW'(oe_on_i);
    assign off_a[S_OE]  = oe_off_i;

    mad_seq #(.TW(TW)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .cyc_i    (cyc_i),
        .accept_o (accept),
        .busy_o   (busy),
        .tick_o   (tick),
        .done_o   (done)
    );

    for (genvar g = 0; g < NSTRB; g++) begin : g_stb
        mad_strobe #(.TW(TW)) u_stb (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .accept_i (accept),
            .on_i     (on_a[g]),
            .off_i    (off_a[g]),
            .cyc_i    (cyc_i),
            .busy_i   (busy),
            .tick_i   (tick),
            .active_o (act[g]),
            .bad_o    (bad[g])
        );
    end

    mad_capture #(.TW(TW), .DW(DW)) u_cap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (accept),
        .acc_i    (acc_i),
        .cyc_i    (cyc_i),
        .busy_i   (busy),
        .tick_i   (tick),
        .ad_i     (ad_i),
        .data_o   (cap_data),
        .bad_o    (acc_bad)
    );

    // address hold and bus release tracking
    always_comb begin
        hold_d = hold_q;
        if (accept) begin
            hold_d.lo   = addr_i[DW:1];
            hold_d.hi   = addr_i[AW-1:DW+1];
            hold_d.be_n = be_n_i;
            hold_d.rel  = 1'b0;
        end else if (busy && act[S_OE]) begin
            hold_d.rel  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= HOLD_RST;
        else         hold_q <= hold_d;
    end

    assign ad_o      = hold_q.lo;
    assign ad_oe_o   = busy && !hold_q.rel && !act[S_OE];
    assign dir_o     = ad_oe_o;
    assign addr_hi_o = hold_q.hi;
    assign be_n_o    = busy ? hold_q.be_n : '1;
    assign cs_n_o    = !act[S_CS];
    assign adv_n_o   = !act[S_ADV];
    assign oe_n_o    = !act[S_OE];
    assign busy_o    = busy;
    assign done_o    = done;
    assign rdata_o   = cap_data;
    assign err_o     = (|bad) || acc_bad;

    // R8
    no_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ad_oe_o |-> oe_n_o);

    // R8
    no_redrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !$past(ad_oe_o)) |-> !ad_oe_o);

    // R7
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(addr_hi_o) && $stable(be_n_o)));

endmodule

// File: tb/mux_ad_rd_ctrl_test.sv
`timescale 1ns/1ps
module mux_ad_rd_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic [26:1] addr;
    logic [1:0]  be_n;
    logic [3:0]  cs_on, adv_on, oe_on;
    logic [4:0]  cs_off, adv_off, oe_off, acc, cyc;
    logic [15:0] dev_word;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe, dir;
    logic [9:0]  addr_hi;
    logic [1:0]  be_n_out;
    logic        cs_n, adv_n, oe_n, busy, done, err;
    logic [15:0] rdata;

    always #2 clk = ~clk;

    // device model: drives its word while output enable is low
    assign ad_in = oe_n ? 16'h0F0F : dev_word;

    mux_ad_rd_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .be_n_i(be_n),
        .cs_on_i(cs_on), .cs_off_i(cs_off), .adv_on_i(adv_on), .adv_off_i(adv_off),
        .oe_on_i(oe_on), .oe_off_i(oe_off), .acc_i(acc), .cyc_i(cyc),
        .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .dir_o(dir),
        .addr_hi_o(addr_hi), .be_n_o(be_n_out), .cs_n_o(cs_n), .adv_n_o(adv_n),
        .oe_n_o(oe_n), .busy_o(busy), .done_o(done), .rdata_o(rdata), .err_o(err)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        tests++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // behavioural reference state
    bit          m_busy, m_done, m_err;
    int          m_tick;
    int          l_on[3], l_off[3], l_acc, l_cyc;
    bit          l_ok[3], l_acc_ok;
    logic [15:0] m_data, m_lo;
    logic [9:0]  m_hi;
    logic [1:0]  m_be;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_tick = 0;
            m_data = '0; m_lo = '0; m_hi = '0; m_be = 2'b11;
            chk("R1 cs_n", cs_n, 1); chk("R1 adv_n", adv_n, 1); chk("R1 oe_n", oe_n, 1);
            chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 ad_oe", ad_oe, 0);
            chk("R1 dir", dir, 0); chk("R1 err", err, 0); chk("R1 be_n", be_n_out, 2'b11);
            chk("R1 addr_hi", addr_hi, 0);
        end else begin
            bit e_act[3];
            bit e_drv;
            for (int i = 0; i < 3; i++)
                e_act[i] = m_busy && l_ok[i] && (m_tick >= l_on[i]) && (m_tick < l_off[i]);
            e_drv = m_busy && !(l_ok[2] && (m_tick >= l_on[2]));
            chk("R2 R3 busy", busy, m_busy);
            chk("R3 done", done, m_done);
            chk("R4 cs_n", cs_n, !e_act[0]);
            chk("R5 adv_n", adv_n, !e_act[1]);
            chk("R6 oe_n", oe_n, !e_act[2]);
            chk("R7 addr_hi", addr_hi, m_hi);
            chk("R7 be_n", be_n_out, m_busy ? m_be : 2'b11);
            chk("R8 ad_oe", ad_oe, e_drv);
            chk("R8 dir", dir, e_drv);
            if (e_drv) chk("R7 ad_o", ad_out, m_lo);
            if (m_done) chk("R9 R10 rdata", rdata, m_data);
            chk("R10 err", err, m_err);
            // advance the reference by one clock
            m_done = 0;
            if (m_busy) begin
                if (l_acc_ok && (m_tick == l_acc)) m_data = ad_in;
                if (m_tick == l_cyc) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_tick++;
                end
            end else if (req) begin
                m_busy = 1; m_tick = 0;
                l_cyc = cyc; l_acc = acc;
                l_on[0] = cs_on;  l_off[0] = cs_off;
                l_on[1] = adv_on; l_off[1] = adv_off;
                l_on[2] = oe_on;  l_off[2] = oe_off;
                for (int i = 0; i < 3; i++) l_ok[i] = (l_on[i] < l_off[i]) && (l_off[i] <= l_cyc);
                l_acc_ok = (l_acc <= l_cyc);
                m_err = !(l_ok[0] && l_ok[1] && l_ok[2] && l_acc_ok);
                m_data = '0;
                m_lo = addr[16:1]; m_hi = addr[26:17]; m_be = be_n;
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL R3 watchdog: cycle never completed actual=%0d expected<=50000", cycles);
            summary();
            $finish;
        end
    end

    task automatic set_cfg(input int a, input int b, input int c, input int d,
                           input int e, input int f, input int g, input int h);
        cs_on = 4'(a); cs_off = 5'(b); adv_on = 4'(c); adv_off = 5'(d);
        oe_on = 4'(e); oe_off = 5'(f); acc = 5'(g); cyc = 5'(h);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    // one read; scramble = change inputs and keep requesting while busy (R2)
    task automatic do_read(input logic [26:1] a, input logic [1:0] b,
                           input logic [15:0] w, input bit scramble);
        @(posedge clk); #1;
        addr = a; be_n = b; dev_word = w; req = 1'b1;
        @(posedge clk); #1;
        if (scramble) begin
            for (int k = 0; k < 4; k++) begin
                addr = ~addr; be_n = ~be_n;
                cs_on = cs_on + 4'd3; oe_off = oe_off - 5'd2; acc = acc + 5'd1; cyc = cyc - 5'd1;
                @(posedge clk); #1;
            end
        end
        req = 1'b0;
        wait_done();
    endtask

    // two reads with no idle gap: request held across the done cycle
    task automatic do_b2b(input logic [26:1] a, input logic [15:0] w);
        @(posedge clk); #1;
        addr = a; be_n = 2'b01; dev_word = w; req = 1'b1;
        wait_done();
        @(posedge clk); #1;
        req = 1'b0;
        wait_done();
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; addr = '0; be_n = 2'b11; dev_word = '0;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // nominal, capture on last OE tick (R4 R5 R6 R9)
        set_cfg(1, 20, 2, 6, 8, 18, 17, 22);
        do_read(26'h2A5C3E1, 2'b00, 16'h1234, 0);
        // strobes from tick 0, capture at OE assertion tick
        set_cfg(0, 5, 0, 2, 2, 5, 2, 5);
        do_read(26'h155A0F0, 2'b10, 16'hBEEF, 0);
        // largest counts
        set_cfg(15, 31, 15, 31, 15, 31, 31, 31);
        do_read(26'h3FFFFFF, 2'b01, 16'hC3A5, 0);
        // error set: CS on==off, OE closes after cycle end, capture past end (R10)
        set_cfg(4, 4, 1, 3, 3, 9, 9, 8);
        do_read(26'h0123456, 2'b00, 16'h7777, 0);
        // minimal cycle length with a window that cannot fit (R10 R3)
        set_cfg(0, 1, 0, 0, 0, 0, 0, 0);
        do_read(26'h0000001, 2'b11, 16'h0001, 0);
        // capture one tick after OE closes (R9 boundary)
        set_cfg(1, 9, 0, 3, 4, 8, 8, 10);
        do_read(26'h2000000, 2'b00, 16'h5A5A, 0);
        // changes while busy must be ignored (R2 R7)
        set_cfg(1, 20, 2, 6, 8, 18, 12, 22);
        do_read(26'h1A2B3C4, 2'b10, 16'h9876, 1);
        // back-to-back requests (R2 R3)
        set_cfg(0, 5, 0, 2, 2, 5, 3, 6);
        do_b2b(26'h0F0F0F0, 16'hABCD);
        repeat (4) @(posedge clk);
        summary();
        $finish;
    end

endmodule